// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Loader

This block accepts tuning and band-select words over a three-wire serial port made of a serial clock, a data line and an enable line. It samples the serial lines into the system clock domain and shifts data bits in on each falling serial-clock edge while enable is high. When the frame is complete it moves the word into holding latches in one step. The latches drive a programmable divider ratio, four band-switch controls and a test-mode selection. A one-cycle strobe marks each completed load.

A static strap input selects the frame length. The long frame has 19 bits and serves the 1/640 and 1/1024 reference ratios. The short frame has 18 bits and serves the 1/512 ratio. The transfer happens on the falling serial-clock edge that ends the frame, not on the enable edge. The latched test field steers a lock-detect output pin. That pin shows the lock indication, the programmable divider tap or the reference divider tap.

Top module: `synth_serial_loader`

## Requirements
- R1: Data is sampled on the falling edge of `ser_clk` (after the two-stage synchronizer) and shifted MSB first, so the first bit sent lands in the most significant frame position.
- R2: While `ser_en` is low, transitions on `ser_clk` and `ser_data` cause no load strobe and leave all latched outputs unchanged.
- R3: With `mode_long`=1 the frame is 19 bits and the latches update on the 19th falling edge. Frame bits [18:15] go to `band_on[3:0]`, bits [14:13] go to `test_sel`, and bits [12:0] go to `ratio`.
- R4: With `mode_long`=0 the frame is 18 bits and the latches update on the 18th falling edge. Bits [17:14] go to `band_on`, bits [13:12] go to `test_sel`, bits [11:0] go to `ratio[11:0]`, and `ratio[12]` is 0.
- R5: If `ser_en` falls before the terminal edge, the partial frame is discarded and the latches keep their contents. The bit count restarts from zero for the next frame.
- R6: A latched 1 in a band bit drives the matching `band_on` output high (on), and a 0 drives it low (off).
- R7: Each completed frame produces exactly one `load_strobe` pulse, one system clock wide, in the cycle the latches take their new value. Further falling edges in the same enable window are ignored.
- R8: `ld_out` follows `div_tap` when `test_sel`=01, follows `ref_tap` when `test_sel`=10, and follows `lock_det` for 00 and 11.
- R9: After reset, `ratio`, `band_on` and `test_sel` are zero, `load_strobe` is low, and `ld_out` follows `lock_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_long | input | 1 | Frame length strap: 1 = 19 bits, 0 = 18 bits |
| ser_clk | input | 1 | Serial clock, data taken on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Serial enable, idles low |
| lock_det | input | 1 | Lock indication from the phase detector |
| div_tap | input | 1 | Programmable divider output tap |
| ref_tap | input | 1 | Reference divider output tap |
| ratio | output | 13 | Latched programmable divider ratio |
| band_on | output | 4 | Latched band-switch controls, 1 = on |
| test_sel | output | 2 | Latched test-mode field |
| ld_out | output | 1 | Lock-detect / test pin |
| load_strobe | output | 1 | One-cycle pulse on each latch update |

## Verification
The bench builds the block with its default parameters: 19-bit and 18-bit frames, four band outputs and two synchronizer stages. This lets it run both frame lengths and the zero-extension of the short ratio field within one run. With these sizes the bench also exercises truncated frames, surplus clock pulses after the terminal edge and clock activity with enable low. Every test-field code is loaded, and the lock-detect pin is checked against each tap.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int TEST_W = 2;

  typedef enum logic [TEST_W-1:0] {
    TM_LOCK  = 2'b00,
    TM_DIV   = 2'b01,
    TM_REF   = 2'b10,
    TM_LOCK2 = 2'b11
  } test_mode_e;
endpackage

// File: rtl/ssl_sync.sv
module ssl_rst_release #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

module ssl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ssl_shifter.sv
module ssl_shifter #(
  parameter int LONG_LEN  = 19,
  parameter int SHORT_LEN = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_s,
  input  logic                sdata_s,
  input  logic                en_s,
  input  logic                mode_long,
  output logic                frame_done,
  output logic [LONG_LEN-1:0] frame_word
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);

  logic                sclk_d_q;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [LONG_LEN-1:0] shreg_q, shreg_n, shifted;
  logic                full_q, full_n;
  logic                fdone_q, fdone_n;
  logic [LONG_LEN-1:0] fword_q, fword_n;
  logic                fall, take, hit;
  logic [CNT_W-1:0]    term_len, cnt_inc;

  // next-state logic
  always_comb begin
    fall     = sclk_d_q & ~sclk_s;
    take     = fall & en_s & ~full_q;
    term_len = mode_long ? LONG_C : SHORT_C;
    cnt_inc  = cnt_q + 1'b1;
    hit      = take && (cnt_inc == term_len);
    shifted  = {shreg_q[LONG_LEN-2:0], sdata_s};

    shreg_n  = take ? shifted : shreg_q;

    if (!en_s)     cnt_n = '0;
    else if (take) cnt_n = cnt_inc;
    else           cnt_n = cnt_q;

    if (!en_s)     full_n = 1'b0;
    else if (hit)  full_n = 1'b1;
    else           full_n = full_q;

    fdone_n = hit;
    fword_n = hit ? shifted : fword_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      full_q   <= 1'b0;
      fdone_q  <= 1'b0;
      fword_q  <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_n;
      shreg_q  <= shreg_n;
      full_q   <= full_n;
      fdone_q  <= fdone_n;
      fword_q  <= fword_n;
    end
  end

  assign frame_done = fdone_q;
  assign frame_word = fword_q;

  // R5: idle enable clears the bit count
  p_cnt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (cnt_q == '0));

  // R3: count never passes the longest frame
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LONG_C);

  // R7: a completed frame freezes the shift register
  p_full_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(shreg_q));

  // R7: a frame-done pulse is only seen with the full flag set
  p_done_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fdone_q |-> full_q);
endmodule

// File: rtl/ssl_latch.sv
module ssl_latch
  import ssl_pkg::*;
#(
  parameter int LONG_LEN  = 19,
  parameter int SHORT_LEN = 18,
  parameter int BAND_N    = 4,
  localparam int RATIO_W  = LONG_LEN - BAND_N - TEST_W,
  localparam int RATIO_S  = SHORT_LEN - BAND_N - TEST_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic [LONG_LEN-1:0] frame_word,
  input  logic                mode_long,
  output logic [RATIO_W-1:0]  ratio,
  output logic [BAND_N-1:0]   band_on,
  output logic [TEST_W-1:0]   test_sel,
  output logic                load_strobe
);
  logic [RATIO_W-1:0] ratio_q, ratio_n, ratio_x;
  logic [BAND_N-1:0]  band_q, band_n, band_x;
  logic [TEST_W-1:0]  test_q, test_n, test_x;
  logic               stb_q;

  // field extraction depends on the strapped frame length
  always_comb begin
    if (mode_long) begin
      band_x  = frame_word[LONG_LEN-1 -: BAND_N];
      test_x  = frame_word[LONG_LEN-BAND_N-1 -: TEST_W];
      ratio_x = frame_word[RATIO_W-1:0];
    end else begin
      band_x  = frame_word[SHORT_LEN-1 -: BAND_N];
      test_x  = frame_word[SHORT_LEN-BAND_N-1 -: TEST_W];
      ratio_x = RATIO_W'(frame_word[RATIO_S-1:0]);
    end
    ratio_n = frame_done ? ratio_x : ratio_q;
    band_n  = frame_done ? band_x  : band_q;
    test_n  = frame_done ? test_x  : test_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      band_q  <= '0;
      test_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      ratio_q <= ratio_n;
      band_q  <= band_n;
      test_q  <= test_n;
      stb_q   <= frame_done;
    end
  end

  assign ratio       = ratio_q;
  assign band_on     = band_q;
  assign test_sel    = test_q;
  assign load_strobe = stb_q;

  // R5: no transfer request means the latches hold
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(ratio_q) && $stable(band_q) && $stable(test_q)));

  // R7: strobe is a single-cycle pulse
  p_strobe_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R7: each transfer request yields a strobe
  p_strobe_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> stb_q);
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import ssl_pkg::*;
#(
  parameter int LONG_LEN    = 19,
  parameter int SHORT_LEN   = 18,
  parameter int BAND_N      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int RATIO_W    = LONG_LEN - BAND_N - TEST_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_long,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_en,
  input  logic               lock_det,
  input  logic               div_tap,
  input  logic               ref_tap,
  output logic [RATIO_W-1:0] ratio,
  output logic [BAND_N-1:0]  band_on,
  output logic [TEST_W-1:0]  test_sel,
  output logic               ld_out,
  output logic               load_strobe
);
  logic                rst_n_s;
  logic [2:0]          ser_s;
  logic                frame_done;
  logic [LONG_LEN-1:0] frame_word;

  ssl_rst_release #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  ssl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .d_async ({ser_en, ser_clk, ser_data}),
    .q_sync  (ser_s)
  );

  ssl_shifter #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sclk_s     (ser_s[1]),
    .sdata_s    (ser_s[0]),
    .en_s       (ser_s[2]),
    .mode_long  (mode_long),
    .frame_done (frame_done),
    .frame_word (frame_word)
  );

  ssl_latch #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .BAND_N(BAND_N)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .frame_done  (frame_done),
    .frame_word  (frame_word),
    .mode_long   (mode_long),
    .ratio       (ratio),
    .band_on     (band_on),
    .test_sel    (test_sel),
    .load_strobe (load_strobe)
  );

  // lock-detect pin source selection
  always_comb begin
    unique case (test_mode_e'(test_sel))
      TM_DIV:  ld_out = div_tap;
      TM_REF:  ld_out = ref_tap;
      default: ld_out = lock_det;
    endcase
  end

  // R8: the test field is only taken from a completed frame
  p_test_load_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(test_sel) |-> load_strobe);

  // R6: band outputs only move together with a load strobe
  p_band_load_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(band_on) |-> load_strobe);
endmodule

// File: tb/synth_serial_loader_tb_top.sv
module synth_serial_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_long = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic ser_en = 1'b0;
  logic lock_det = 1'b0;
  logic div_tap = 1'b0;
  logic ref_tap = 1'b0;
  logic [12:0] ratio;
  logic [3:0]  band_on;
  logic [1:0]  test_sel;
  logic        ld_out;
  logic        load_strobe;

  int tests = 0;
  int fails = 0;

  typedef struct packed {
    logic [12:0] r;
    logic [3:0]  b;
    logic [1:0]  t;
  } exp_t;

  exp_t exp_q[$];
  exp_t last = '0;

  always #5 clk = ~clk;

  synth_serial_loader dut_i (
    .clk(clk), .rst_n(rst_n), .mode_long(mode_long),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .lock_det(lock_det), .div_tap(div_tap), .ref_tap(ref_tap),
    .ratio(ratio), .band_on(band_on), .test_sel(test_sel),
    .ld_out(ld_out), .load_strobe(load_strobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected fields from the first frame-length bits sent
  function automatic exp_t expect_of(input int nbits, input logic [31:0] bits, input bit lng);
    exp_t e;
    logic [31:0] f;
    if (lng) begin
      f   = bits >> (nbits - 19);
      e.b = f[18:15];
      e.t = f[14:13];
      e.r = f[12:0];
    end else begin
      f   = bits >> (nbits - 18);
      e.b = f[17:14];
      e.t = f[13:12];
      e.r = {1'b0, f[11:0]};
    end
    return e;
  endfunction

  task automatic send(input int nbits, input logic [31:0] bits, input bit lng, input bit full);
    mode_long = lng;
    if (full) exp_q.push_back(expect_of(nbits, bits, lng));
    repeat (4) @(posedge clk);
    ser_en = 1'b1;
    repeat (6) @(posedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = bits[i];
      repeat (4) @(posedge clk);
      ser_clk = 1'b1;
      repeat (8) @(posedge clk);
      ser_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    repeat (6) @(posedge clk);
    ser_en = 1'b0;
    repeat (12) @(posedge clk);
  endtask

  task automatic pulses_no_enable(input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = i[0];
      repeat (4) @(posedge clk);
      ser_clk = 1'b1;
      repeat (8) @(posedge clk);
      ser_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    repeat (12) @(posedge clk);
  endtask

  task automatic check_held(input string req);
    @(negedge clk);
    check({req, " ratio"}, 32'(ratio), 32'(last.r));
    check({req, " band"},  32'(band_on), 32'(last.b));
    check({req, " test"},  32'(test_sel), 32'(last.t));
  endtask

  task automatic check_ld(input logic l, input logic d, input logic r, input logic expv);
    lock_det = l; div_tap = d; ref_tap = r;
    @(negedge clk);
    check("R8 ld_out", 32'(ld_out), 32'(expv));
  endtask

  // monitor / scoreboard
  logic prev_stb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stb && load_strobe) begin
        tests++; fails++;
        $display("FAIL R7 strobe wider than one cycle actual=1 expected=0");
      end
      if (load_strobe) begin
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R2/R5/R7 unexpected load strobe actual=1 expected=0");
        end else begin
          last = exp_q.pop_front();
          check("R1 R3 R4 ratio", 32'(ratio), 32'(last.r));
          check("R6 band_on", 32'(band_on), 32'(last.b));
          check("R3 R4 test_sel", 32'(test_sel), 32'(last.t));
        end
      end
    end
    prev_stb <= load_strobe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 ratio", 32'(ratio), 0);
    check("R9 band", 32'(band_on), 0);
    check("R9 test", 32'(test_sel), 0);
    check("R9 strobe", 32'(load_strobe), 0);
    lock_det = 1'b1;
    @(negedge clk);
    check("R9 ld_out", 32'(ld_out), 1);
    lock_det = 1'b0;

    // R3 long frame, test field 01
    send(19, 32'b1010_01_1001101011010, 1'b1, 1'b1);
    check_ld(1'b0, 1'b1, 1'b0, 1'b1);
    check_ld(1'b1, 1'b0, 1'b1, 1'b0);

    // R2 clock activity with enable low
    pulses_no_enable(19);
    check_held("R2");

    // R5 truncated frame discarded
    send(10, 32'h3FF, 1'b1, 1'b0);
    check_held("R5");

    // R5 following full frame counts from zero; test field 10
    send(19, 32'b0101_10_0110010100101, 1'b1, 1'b1);
    check_ld(1'b0, 1'b0, 1'b1, 1'b1);
    check_ld(1'b1, 1'b1, 1'b0, 1'b0);

    // R4 short frame, all-ones ratio field, test 11
    send(18, 32'b1111_11_111111111111, 1'b0, 1'b1);
    check_ld(1'b1, 1'b0, 1'b0, 1'b1);
    check_ld(1'b0, 1'b1, 1'b1, 1'b0);

    // R4 short frame truncated at 17 bits
    send(17, 32'h0, 1'b0, 1'b0);
    check_held("R4 short truncated");

    // R7 surplus pulses after the terminal edge, test 00
    send(21, 32'b0011_00_1000000000001_11, 1'b1, 1'b1);
    check_ld(1'b1, 1'b0, 1'b0, 1'b1);
    check_held("R7 surplus");

    // R6 all bands on then off
    send(18, 32'b1111_00_000000000001, 1'b0, 1'b1);
    send(19, 32'b0000_00_0000000000000, 1'b1, 1'b1);
    check_held("R6 off");

    repeat (20) @(posedge clk);
    check("R7 pending loads", 32'(exp_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule